// File: doc/BRIEF.md
# Byte-Serial Iterative AES Encryption Core

This block encrypts one 128-bit block at a time. The block arrives over an 8-bit stream, one byte on each cycle that carries a valid strobe. Once sixteen bytes have been collected, the core runs the initial key addition and then one full cipher round per clock. The final round skips the column mixing step. The result leaves over a second 8-bit stream as sixteen consecutive bytes, each marked with an output valid strobe.

Round keys are not stored inside the block. The core drives a round index, and a key expander beside it must return the matching 128-bit round key in the same cycle. A ready output lets an upstream scheduler see whether the core can take a new block. Ready falls after the first byte of a block is accepted. It stays low through the cipher and the output phase, and it returns in the cycle after the last result byte has been presented.

Top module: `aes_bytecore`

## Requirements
- R1: After reset, `rdy` is high and `dout_vld` is low.
- R2: While the core is idle or collecting, each cycle with `din_vld` high takes exactly one byte, and cycles with `din_vld` low between bytes are allowed. The first byte taken is the most significant byte of the block (bits 127:120), which is byte 0 of the cipher state (row 0, column 0).
- R3: `rdy` goes low in the cycle after the first byte is accepted and stays low until the output phase ends. Any `din_vld` that arrives after the sixteenth byte and before `rdy` rises again is ignored, and it changes neither the current result nor the next block.
- R4: The key-size code is sampled together with the first byte of a block: 0 selects 10 rounds with a 128-bit key, 1 selects 12 rounds with a 192-bit key, and 2 or 3 selects 14 rounds with a 256-bit key. Later changes to the code during that block have no effect.
- R5: `rk_idx` is 0 in the cycle after the sixteenth byte is taken, then counts 1, 2, … up to the round count, advancing by one each cycle. `rk` must hold that round's key in the same cycle.
- R6: The first result byte is presented with `dout_vld` high exactly Nr+1 cycles after the clock edge that takes the sixteenth input byte, where Nr is the round count.
- R7: The result appears as 16 consecutive bytes with `dout_vld` high, most significant byte first. It equals the AES encryption of the block, with column mixing in every round except the last.
- R8: `rdy` rises in the same cycle that `dout_vld` falls. A first byte offered in that cycle starts the next block.
- R9: The core reproduces the standard AES known-answer ciphertexts for the 128-, 192- and 256-bit example keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_len | input | 2 | Key-size code, sampled with the first byte |
| din | input | 8 | Input data byte |
| din_vld | input | 1 | Input byte strobe |
| rdy | output | 1 | High when a new block may begin |
| rk_idx | output | 4 | Index of the round key needed this cycle |
| rk | input | 128 | Round key for `rk_idx`, supplied in the same cycle |
| dout | output | 8 | Result byte |
| dout_vld | output | 1 | Result byte strobe |

## Verification
A round counter that is off by one changes both the number of cycles before `dout_vld` rises and the sequence seen on `rk_idx`. The `rk_idx` error is visible within a few cycles of the last input byte, and the latency error one cycle before the first output. A fault in the S-box, the row shift or the column mix, or a misplaced input byte, corrupts the ciphertext as soon as the first output byte appears, and the known-answer vectors expose it. A state machine that leaves busy too early or too late shows up as `rdy` disagreeing with `dout_vld` on the cycle the output ends. It also shows up when stray strobes offered while the core is busy alter a later block.

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;

   localparam int STATE_W = 128;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOAD,
      S_KEY0,
      S_RND,
      S_OUT
   } core_st_e;

   // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_x2(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p;
      logic [7:0] t;
      p = 8'h00;
      t = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ t;
         t = gf_x2(t);
      end
      return p;
   endfunction

   // inverse as a^254; zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] r;
      logic [7:0] base;
      r    = 8'h01;
      base = a;
      for (int i = 0; i < 8; i++) begin
         if (i != 0) r = gf_mul(r, base);
         base = gf_mul(base, base);
      end
      return r;
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [7:0] sub_byte(input logic [7:0] a);
      logic [7:0] b;
      b = gf_inv(a);
      return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
   endfunction

   function automatic logic [3:0] rounds_for(input logic [1:0] ksel);
      case (ksel)
         2'd0:    return 4'd10;
         2'd1:    return 4'd12;
         default: return 4'd14;
      endcase
   endfunction

endpackage

// File: rtl/aes_in_collect.sv
module aes_in_collect #(
   parameter int N_BYTES = 16,
   localparam int BLK_W = 8 * N_BYTES,
   localparam int CNT_W = $clog2(N_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [7:0]       din,
   output logic [BLK_W-1:0] blk,
   output logic             full
);

   logic [CNT_W-1:0] cnt;

   assign full = take && (cnt == CNT_W'(N_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         blk <= '0;
      end else if (take) begin
         blk <= {blk[BLK_W-9:0], din};
         cnt <= full ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/aes_round.sv
module aes_round
   import aes_core_pkg::*;
(
   input  logic [STATE_W-1:0] s_in,
   input  logic [STATE_W-1:0] rkey,
   input  logic               final_rnd,
   output logic [STATE_W-1:0] s_out
);

   logic [7:0] sb  [16];
   logic [7:0] sh  [16];
   logic [7:0] mx  [16];

   for (genvar i = 0; i < 16; i++) begin : g_sub
      assign sb[i] = sub_byte(s_in[STATE_W-1-8*i -: 8]);
   end

   for (genvar c = 0; c < 4; c++) begin : g_col
      for (genvar r = 0; r < 4; r++) begin : g_row
         assign sh[r + 4*c] = sb[r + 4*((c + r) % 4)];
      end
      assign mx[4*c + 0] = gf_x2(sh[4*c]) ^ gf_x2(sh[4*c+1]) ^ sh[4*c+1] ^ sh[4*c+2] ^ sh[4*c+3];
      assign mx[4*c + 1] = sh[4*c] ^ gf_x2(sh[4*c+1]) ^ gf_x2(sh[4*c+2]) ^ sh[4*c+2] ^ sh[4*c+3];
      assign mx[4*c + 2] = sh[4*c] ^ sh[4*c+1] ^ gf_x2(sh[4*c+2]) ^ gf_x2(sh[4*c+3]) ^ sh[4*c+3];
      assign mx[4*c + 3] = gf_x2(sh[4*c]) ^ sh[4*c] ^ sh[4*c+1] ^ sh[4*c+2] ^ gf_x2(sh[4*c+3]);
   end

   for (genvar i = 0; i < 16; i++) begin : g_key
      assign s_out[STATE_W-1-8*i -: 8] = (final_rnd ? sh[i] : mx[i]) ^ rkey[STATE_W-1-8*i -: 8];
   end

endmodule

// File: rtl/aes_out_serial.sv
module aes_out_serial #(
   parameter int N_BYTES = 16,
   localparam int BLK_W = 8 * N_BYTES,
   localparam int CNT_W = $clog2(N_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BLK_W-1:0] res,
   output logic [7:0]       dout,
   output logic             vld,
   output logic             last
);

   logic [BLK_W-1:0] sh;
   logic [CNT_W-1:0] cnt;

   assign dout = sh[BLK_W-1 -: 8];
   assign last = vld && (cnt == CNT_W'(N_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
         vld <= 1'b0;
      end else if (load) begin
         sh  <= res;
         cnt <= '0;
         vld <= 1'b1;
      end else if (vld) begin
         sh  <= {sh[BLK_W-9:0], 8'h00};
         cnt <= cnt + 1'b1;
         if (last) vld <= 1'b0;
      end
   end

endmodule

// File: rtl/aes_bytecore.sv
module aes_bytecore
   import aes_core_pkg::*;
#(
   parameter int N_BYTES = 16,
   parameter int KSEL_W  = 2,
   parameter int RIDX_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [KSEL_W-1:0]    key_len,
   input  logic [7:0]           din,
   input  logic                 din_vld,
   output logic                 rdy,
   output logic [RIDX_W-1:0]    rk_idx,
   input  logic [8*N_BYTES-1:0] rk,
   output logic [7:0]           dout,
   output logic                 dout_vld
);

   localparam int BLK_W = 8 * N_BYTES;

   if (BLK_W != STATE_W) begin : g_bad_width
      $error("aes_bytecore: N_BYTES must give a 128-bit block");
   end
   if (RIDX_W < 4) begin : g_bad_ridx
      $error("aes_bytecore: RIDX_W must hold round index 14");
   end
   if (KSEL_W != 2) begin : g_bad_ksel
      $error("aes_bytecore: KSEL_W must be 2");
   end

   core_st_e          fsm;
   logic [RIDX_W-1:0] rnd;
   logic [RIDX_W-1:0] nr_q;
   logic [BLK_W-1:0]  st;
   logic [BLK_W-1:0]  blk;
   logic [BLK_W-1:0]  rnd_out;
   logic              take;
   logic              full;
   logic              last_rnd;
   logic              ser_load;
   logic              ser_last;

   assign take     = din_vld && (fsm == S_IDLE || fsm == S_LOAD);
   assign last_rnd = (rnd == nr_q);
   assign ser_load = (fsm == S_RND) && last_rnd;
   assign rdy      = (fsm == S_IDLE);
   assign rk_idx   = (fsm == S_RND) ? rnd : '0;

   aes_in_collect #(.N_BYTES(N_BYTES)) u_in (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .din   (din),
      .blk   (blk),
      .full  (full)
   );

   aes_round u_rnd (
      .s_in      (st),
      .rkey      (rk),
      .final_rnd (last_rnd),
      .s_out     (rnd_out)
   );

   aes_out_serial #(.N_BYTES(N_BYTES)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ser_load),
      .res   (rnd_out),
      .dout  (dout),
      .vld   (dout_vld),
      .last  (ser_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm  <= S_IDLE;
         rnd  <= '0;
         nr_q <= RIDX_W'(10);
         st   <= '0;
      end else begin
         case (fsm)
            S_IDLE: if (take) begin
               nr_q <= RIDX_W'(rounds_for(key_len));
               fsm  <= S_LOAD;
            end
            S_LOAD: if (full) fsm <= S_KEY0;
            S_KEY0: begin
               st  <= blk ^ rk;
               rnd <= RIDX_W'(1);
               fsm <= S_RND;
            end
            S_RND: begin
               st  <= rnd_out;
               rnd <= rnd + 1'b1;
               if (last_rnd) fsm <= S_OUT;
            end
            S_OUT: if (ser_last) fsm <= S_IDLE;
            default: fsm <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/aes_bytecore_chk.sv
module aes_bytecore_chk #(
   parameter int RIDX_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              din_vld,
   input logic              rdy,
   input logic [RIDX_W-1:0] rk_idx,
   input logic              dout_vld
);

   logic [4:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n) run <= '0;
      else        run <= dout_vld ? run + 1'b1 : '0;
   end

   // R3
   rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && din_vld) |=> !rdy);

   // R3
   busy_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> !rdy);

   // R8
   ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout_vld) |-> rdy);

   // R7
   out_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout_vld) |-> (run == 5'd16));

   // R7
   out_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> (run < 5'd16));

   // R5
   rk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rk_idx <= RIDX_W'(14));

   // R5
   rk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rk_idx != '0) |=> (rk_idx == '0 || rk_idx == $past(rk_idx) + 1'b1));

endmodule

bind aes_bytecore aes_bytecore_chk #(.RIDX_W(RIDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .din_vld  (din_vld),
   .rdy      (rdy),
   .rk_idx   (rk_idx),
   .dout_vld (dout_vld)
);

// File: tb/aes_bytecore_test.sv
`timescale 1ns/1ps
module aes_bytecore_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   key_len = 2'd0;
   logic [7:0]   din = 8'h00;
   logic         din_vld = 1'b0;
   logic         rdy;
   logic [3:0]   rk_idx;
   logic [127:0] rk;
   logic [7:0]   dout;
   logic         dout_vld;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0]   sbt [256];
   logic [127:0] rkeys [15];

   always #2.5 clk = ~clk;

   assign rk = (rk_idx < 4'd15) ? rkeys[rk_idx] : 128'h0;

   aes_bytecore uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_len  (key_len),
      .din      (din),
      .din_vld  (din_vld),
      .rdy      (rdy),
      .rk_idx   (rk_idx),
      .rk       (rk),
      .dout     (dout),
      .dout_vld (dout_vld)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rl(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [7:0] x2(input logic [7:0] a);
      return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
   endfunction

   task automatic build_sbox();
      logic [7:0] p, q, x;
      p = 8'h01;
      q = 8'h01;
      do begin
         p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
         q = q ^ {q[6:0], 1'b0};
         q = q ^ {q[5:0], 2'b00};
         q = q ^ {q[3:0], 4'h0};
         if (q[7]) q = q ^ 8'h09;
         x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
         sbt[p] = x ^ 8'h63;
      end while (p != 8'h01);
      sbt[0] = 8'h63;
   endtask

   function automatic int nr_of(input logic [1:0] k);
      return (k == 2'd0) ? 10 : (k == 2'd1) ? 12 : 14;
   endfunction

   function automatic logic [31:0] subw(input logic [31:0] w);
      return {sbt[w[31:24]], sbt[w[23:16]], sbt[w[15:8]], sbt[w[7:0]]};
   endfunction

   task automatic build_keys(input logic [1:0] k, input logic [255:0] key);
      logic [31:0] w [60];
      logic [31:0] t;
      logic [7:0]  rc;
      int nk, nr;
      nr = nr_of(k);
      nk = nr - 6;
      rc = 8'h01;
      for (int i = 0; i < 4 * (nr + 1); i++) begin
         if (i < nk) w[i] = key[255 - 32*i -: 32];
         else begin
            t = w[i-1];
            if (i % nk == 0) begin
               t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
               rc = x2(rc);
            end else if (nk > 6 && i % nk == 4) t = subw(t);
            w[i] = w[i-nk] ^ t;
         end
      end
      for (int r = 0; r < 15; r++)
         rkeys[r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : 128'h0;
   endtask

   function automatic logic [127:0] enc_ref(input logic [127:0] pt, input int nr);
      logic [127:0] s;
      logic [7:0] b [16];
      logic [7:0] t [16];
      logic [7:0] a0, a1, a2, a3;
      s = pt ^ rkeys[0];
      for (int r = 1; r <= nr; r++) begin
         for (int i = 0; i < 16; i++) b[i] = sbt[s[127 - 8*i -: 8]];
         for (int c = 0; c < 4; c++)
            for (int w = 0; w < 4; w++) t[w + 4*c] = b[w + 4*((c + w) % 4)];
         if (r != nr) begin
            for (int c = 0; c < 4; c++) begin
               a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
               t[4*c]   = x2(a0 ^ a1) ^ a1 ^ a2 ^ a3;
               t[4*c+1] = x2(a1 ^ a2) ^ a0 ^ a2 ^ a3;
               t[4*c+2] = x2(a2 ^ a3) ^ a0 ^ a1 ^ a3;
               t[4*c+3] = x2(a3 ^ a0) ^ a0 ^ a1 ^ a2;
            end
         end
         for (int i = 0; i < 16; i++) s[127 - 8*i -: 8] = t[i];
         s = s ^ rkeys[r];
      end
      return s;
   endfunction

   task automatic do_block(input logic [1:0] k, input logic [255:0] key, input logic [127:0] pt,
                           input logic [127:0] kat, input bit use_kat, input bit gaps,
                           input bit noise, input bit flip, input bit imm);
      logic [127:0] exp, res;
      int nr, got, first_k;
      bit idx_ok, rdy_ok;
      nr = nr_of(k);
      build_keys(k, key);
      exp = use_kat ? kat : enc_ref(pt, nr);
      res = '0; got = 0; first_k = -1; idx_ok = 1; rdy_ok = 1;
      for (int i = 0; i < 16; i++) begin
         if (i > 0 || !imm) @(negedge clk);
         if (i == 0) chk(rdy == 1'b1, "R8 ready before block", {127'h0, rdy}, 128'h1);
         if (i == 1) chk(rdy == 1'b0, "R3 ready low after first byte", {127'h0, rdy}, 128'h0);
         while (gaps && i > 0 && ($urandom % 3 == 0)) begin
            din_vld = 1'b0;
            din = 8'($urandom);
            @(negedge clk);
         end
         din = pt[127 - 8*i -: 8];
         din_vld = 1'b1;
         key_len = (i == 0 || !flip) ? k : ~k;
      end
      for (int kk = 0; kk <= nr + 16; kk++) begin
         @(negedge clk);
         if (kk <= nr && rk_idx != 4'(kk)) idx_ok = 0;
         if (rdy) rdy_ok = 0;
         if (dout_vld) begin
            if (first_k < 0) first_k = kk;
            res = {res[119:0], dout};
            got++;
         end
         if (noise && kk <= nr + 14) begin
            din_vld = 1'b1;
            din = 8'($urandom);
         end else din_vld = 1'b0;
      end
      chk(idx_ok, "R5 round key index sequence", 128'(nr), 128'(nr));
      chk(first_k == nr + 1, "R6 R4 first output latency", 128'(first_k), 128'(nr + 1));
      chk(got == 16, "R7 output byte count", 128'(got), 128'd16);
      chk(res == exp, use_kat ? "R9 R7 R2 known answer" : "R7 R2 R3 R4 ciphertext", res, exp);
      chk(rdy_ok, "R3 ready held low while busy", {127'h0, rdy_ok}, 128'h1);
      @(negedge clk);
      chk(dout_vld == 1'b0 && rdy == 1'b1, "R8 ready returns as output ends",
          {126'h0, dout_vld, rdy}, 128'h1);
   endtask

   initial begin
      #750000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [255:0] key;
      logic [127:0] pt;
      void'($urandom(32'h5eed_a3e5));
      build_sbox();
      repeat (3) @(negedge clk);
      chk(rdy == 1'b1, "R1 ready after reset", {127'h0, rdy}, 128'h1);
      chk(dout_vld == 1'b0, "R1 no output after reset", {127'h0, dout_vld}, 128'h0);
      rst_n = 1'b1;
      pt = 128'h00112233445566778899aabbccddeeff;
      key = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
      do_block(2'd0, {key[255:128], 128'h0}, pt, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1, 0, 0, 0, 0);
      do_block(2'd1, {key[255:64], 64'h0}, pt, 128'hdda97ca4864cdfe06eaf70a0ec0d7191, 1, 0, 0, 0, 1);
      do_block(2'd2, key, pt, 128'h8ea2b7ca516745bfeafc49904b496089, 1, 1, 1, 0, 0);
      // R4 code 3 selects the 256-bit schedule, key-size change after first byte ignored
      do_block(2'd3, key, pt, 128'h8ea2b7ca516745bfeafc49904b496089, 1, 0, 0, 1, 1);
      for (int j = 0; j < 12; j++) begin
         logic [1:0] k;
         k = 2'($urandom % 4);
         key = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
         if (k == 2'd0) key[127:0] = '0;
         if (k == 2'd1) key[63:0] = '0;
         pt = {$urandom, $urandom, $urandom, $urandom};
         do_block(k, key, pt, 128'h0, 0, j % 3 != 0, j % 2 == 0, j % 4 == 1, j % 2 == 1);
      end
      // R2 all-ones and all-zero blocks under a 128-bit key
      do_block(2'd0, 256'h0, 128'h0, 128'h0, 0, 0, 1, 0, 0);
      do_block(2'd0, {128{2'b10}}, {128{1'b1}}, 128'h0, 0, 1, 0, 1, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule